// File: doc/BRIEF.md
# Scaled-Index Address Generation Unit

This block forms a 32-bit effective address from up to three pieces: a base register value, an index register value shifted left by a small scale amount, and a displacement. The displacement is either a full 32-bit immediate or an 8-bit immediate that is sign-extended. A two-bit mode input chooses which of these pieces take part in the sum. Every sum wraps modulo 2^32.

Each accepted request takes one of two paths. A memory request places the address on the memory port and raises a request strobe. An address-only request returns the same address as a register result and starts no memory access. Either kind of request may also ask for base update. In that case the computed address is returned as the new base value, so a loop can walk an array with no separate add. All outputs are registered, and a result appears one cycle after its request.

Top module: `agu_scaled_index`

## Requirements
- R1: While reset is active and after it is released, with no request presented, out_valid, mem_req, res_valid and base_we are 0, and addr, res_data and base_data are 0.
- R2: Mode 0 (mode = 2'b00) produces addr = base + displacement. The index and the scale have no effect.
- R3: Mode 1 (mode = 2'b01) produces addr = base + index. The displacement and the scale have no effect.
- R4: Mode 2 (mode = 2'b10) produces addr = base + (index << scale). The displacement has no effect. The 2-bit scale selects multipliers 1, 2, 4 and 8 for codes 0, 1, 2 and 3.
- R5: Mode 3 (mode = 2'b11) produces addr = base + (index << scale) + displacement.
- R6: When disp_wide = 1 the displacement is all 32 bits of disp. When disp_wide = 0 it is disp[7:0] sign-extended to 32 bits, and disp[31:8] have no effect.
- R7: All additions and the index shift wrap modulo 2^32.
- R8: A request with lea = 0 gives mem_req = 1 and res_valid = 0 in the result cycle.
- R9: A request with lea = 1 gives res_valid = 1, res_data equal to addr, and mem_req = 0 in the result cycle.
- R10: A request with update = 1 gives base_we = 1 and base_data equal to the computed address. A request with update = 0 gives base_we = 0.
- R11: out_valid is 1 in exactly the cycle after a cycle in which in_valid is 1. After a cycle with in_valid = 0, out_valid, mem_req, res_valid and base_we are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Request strobe |
| mode | input | 2 | Address combination select |
| lea | input | 1 | 1 = return address as register result, no memory access |
| update | input | 1 | 1 = also return computed address as new base |
| base | input | 32 | Base register value |
| index | input | 32 | Index register value |
| scale | input | 2 | Index left-shift amount |
| disp | input | 32 | Displacement immediate |
| disp_wide | input | 1 | 1 = 32-bit displacement, 0 = sign-extended 8-bit |
| out_valid | output | 1 | Registered result valid |
| addr | output | 32 | Effective address |
| mem_req | output | 1 | Memory access request |
| res_valid | output | 1 | Register result valid (address-only request) |
| res_data | output | 32 | Register result value |
| base_we | output | 1 | Base rewrite enable |
| base_data | output | 32 | New base value |

## Verification
The bench sweeps every mode, scale code, displacement size, path and update setting against several operand sets. The displacement sets use byte values with the top bit set and deliberately filled upper bits. A unit that zero-extended the short displacement, or that let its upper bits through, would then give addresses off by a multiple of 256. Operand sets near the top of the address space check wrap-around, and a carry kept past bit 31 or a shift done before truncation would show as a wrong address. Idle cycles between requests catch strobes that stick, a memory request raised on the address-only path, and an update that fires when it was not requested.

// File: rtl/agu_scaled_index.sv
module agu_scaled_index #(
  parameter int AW = 32,
  parameter int NARROW_W = 8,
  parameter int SCALE_W = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [1:0]         mode,
  input  logic               lea,
  input  logic               update,
  input  logic [AW-1:0]      base,
  input  logic [AW-1:0]      index,
  input  logic [SCALE_W-1:0] scale,
  input  logic [AW-1:0]      disp,
  input  logic               disp_wide,
  output logic               out_valid,
  output logic [AW-1:0]      addr,
  output logic               mem_req,
  output logic               res_valid,
  output logic [AW-1:0]      res_data,
  output logic               base_we,
  output logic [AW-1:0]      base_data
);
  localparam int EXT_W = AW - NARROW_W;

  typedef enum logic [1:0] {
    M_BASE_DISP   = 2'b00,
    M_BASE_INDEX  = 2'b01,
    M_SCALED      = 2'b10,
    M_SCALED_DISP = 2'b11
  } mode_e;

  logic [AW-1:0] disp_ext, scaled_idx, ea;

  assign disp_ext   = disp_wide ? disp : {{EXT_W{disp[NARROW_W-1]}}, disp[NARROW_W-1:0]};
  assign scaled_idx = index << scale;

  always_comb begin
    unique case (mode_e'(mode))
      M_BASE_DISP:   ea = base + disp_ext;
      M_BASE_INDEX:  ea = base + index;
      M_SCALED:      ea = base + scaled_idx;
      M_SCALED_DISP: ea = base + scaled_idx + disp_ext;
      default:       ea = base;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      mem_req   <= 1'b0;
      res_valid <= 1'b0;
      base_we   <= 1'b0;
      addr      <= '0;
      res_data  <= '0;
      base_data <= '0;
    end else begin
      out_valid <= in_valid;
      mem_req   <= in_valid & ~lea;
      res_valid <= in_valid & lea;
      base_we   <= in_valid & update;
      if (in_valid) begin
        addr <= ea;
        if (lea)    res_data  <= ea;
        if (update) base_data <= ea;
      end
    end
  end

  a_r11_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r11_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid && !mem_req && !res_valid && !base_we);
  a_r8_mem_path: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && !lea |=> mem_req && !res_valid);
  a_r9_lea_path: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && lea |=> !mem_req && res_valid && res_data == addr);
  a_r10_update: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && update |=> base_we && base_data == addr);
  a_r3_base_index: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'b01 |=> addr == $past(base) + $past(index));
  a_r2_base_disp_wide: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && mode == 2'b00 && disp_wide |=> addr == $past(base) + $past(disp));
endmodule

// File: tb/tb_agu_scaled_index.sv
module tb_agu_scaled_index;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        in_valid, lea, update, disp_wide;
  logic [1:0]  mode, scale;
  logic [31:0] base, index, disp;
  logic        out_valid, mem_req, res_valid, base_we;
  logic [31:0] addr, res_data, base_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  agu_scaled_index dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .mode(mode), .lea(lea),
    .update(update), .base(base), .index(index), .scale(scale), .disp(disp),
    .disp_wide(disp_wide), .out_valid(out_valid), .addr(addr), .mem_req(mem_req),
    .res_valid(res_valid), .res_data(res_data), .base_we(base_we), .base_data(base_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp_v);
    checks++;
    if (act !== exp_v) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp_v);
    end
  endtask

  function automatic logic [31:0] model(input logic [1:0] m, input logic [1:0] s,
      input logic [31:0] b, input logic [31:0] i, input logic [31:0] d, input logic w);
    logic [63:0] dx, sum;
    dx = w ? {32'h0, d} : {{56{d[7]}}, d[7:0]};
    case (m)
      2'd0: sum = {32'h0, b} + dx;
      2'd1: sum = {32'h0, b} + {32'h0, i};
      2'd2: sum = {32'h0, b} + ({32'h0, i} * (64'd1 << s));
      default: sum = {32'h0, b} + ({32'h0, i} * (64'd1 << s)) + dx;
    endcase
    return sum[31:0];
  endfunction

  task automatic idle_check();
    in_valid = 1'b0;
    lea = 1'b1; update = 1'b1;
    @(negedge clk);
    chk("R11 out_valid idle", {31'h0, out_valid}, 32'h0);
    chk("R11 strobes idle", {29'h0, mem_req, res_valid, base_we}, 32'h0);
  endtask

  initial begin
    logic [31:0] bases [4];
    logic [31:0] idxs [4];
    logic [31:0] disps [4];
    bases[0] = 32'h0000_1000; idxs[0] = 32'h0000_0010; disps[0] = 32'h0000_0004;
    bases[1] = 32'hFFFF_FFF0; idxs[1] = 32'h4000_0003; disps[1] = 32'hABCD_EF80;
    bases[2] = 32'h8000_0000; idxs[2] = 32'hFFFF_FFFF; disps[2] = 32'h1234_56FF;
    bases[3] = 32'h0000_00FF; idxs[3] = 32'h2000_0001; disps[3] = 32'hFFFF_FF7F;

    rst_n = 1'b0; in_valid = 1'b0; lea = 1'b0; update = 1'b0; disp_wide = 1'b0;
    mode = 2'd0; scale = 2'd0; base = '0; index = '0; disp = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset out_valid", {31'h0, out_valid}, 32'h0);
    chk("R1 reset strobes", {29'h0, mem_req, res_valid, base_we}, 32'h0);
    chk("R1 reset addr", addr, 32'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 idle after reset", {28'h0, out_valid, mem_req, res_valid, base_we}, 32'h0);
    chk("R1 res_data", res_data, 32'h0);
    chk("R1 base_data", base_data, 32'h0);

    for (int m = 0; m < 4; m++)
      for (int s = 0; s < 4; s++)
        for (int w = 0; w < 2; w++)
          for (int l = 0; l < 2; l++)
            for (int u = 0; u < 2; u++)
              for (int p = 0; p < 4; p++) begin
                logic [31:0] e;
                string tag;
                in_valid = 1'b1; mode = m[1:0]; scale = s[1:0]; disp_wide = w[0];
                lea = l[0]; update = u[0];
                base = bases[p]; index = idxs[p]; disp = disps[p];
                e = model(m[1:0], s[1:0], bases[p], idxs[p], disps[p], w[0]);
                case (m)
                  0: tag = (w == 0) ? "R2 R6 R7 mode0 addr" : "R2 R7 mode0 addr";
                  1: tag = "R3 R7 mode1 addr";
                  2: tag = "R4 R7 mode2 addr";
                  default: tag = (w == 0) ? "R5 R6 R7 mode3 addr" : "R5 R7 mode3 addr";
                endcase
                @(negedge clk);
                chk(tag, addr, e);
                chk("R11 out_valid", {31'h0, out_valid}, 32'h1);
                chk("R8 R9 mem_req", {31'h0, mem_req}, {31'h0, ~l[0]});
                chk("R8 R9 res_valid", {31'h0, res_valid}, {31'h0, l[0]});
                if (l == 1) chk("R9 res_data", res_data, e);
                chk("R10 base_we", {31'h0, base_we}, {31'h0, u[0]});
                if (u == 1) chk("R10 base_data", base_data, e);
                if (p == 3) idle_check();
              end

    idle_check();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule